// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a serial peripheral interface for a small non-volatile byte memory. It samples the serial clock, data-in, select and pause lines with the system clock. It shifts in a command byte, an address and data bytes, and drives the serial data-out line together with a separate output-enable. What it receives becomes single-cycle requests on a parallel side: setting or clearing the write latch, writing the status byte, fetching array bytes and loading page bytes, with a commit or abort when select rises. The storage array, the write timer and the protection policy sit behind that parallel side. They feed back only the busy flag, the status byte and the fetched array byte.

The serial clock may idle low or high (modes 0 and 3). Input bits are sampled on rising serial clock edges and output bits change on falling edges. A pause line freezes a transfer in the middle without losing its position. An unknown command byte shuts the interface until the next select.

Top module: `spi_mem_front`

## Requirements
- R1: Command, address and data bits travel most significant bit first; the block works with the serial clock idling low (mode 0) or high (mode 3), sampling on rising edges and changing data-out after falling edges.
- R2: The first 8 bits after select falls form the command byte; bits 7..4 must be zero, bit 3 is ignored, and bits 2..0 select: 110 set write latch, 100 clear write latch, 101 read status, 001 write status, 011 read array, 010 write array; set and clear each raise their single-cycle pulse once, right after the eighth bit.
- R3: Any other command byte makes the block ignore all further bits and keep data-out disabled until select falls again.
- R4: While select is high, serial clock and data-in have no effect and the output-enable is low.
- R5: Pulling the pause input low while the serial clock is low starts a pause; raising it while the clock is low ends it; during a pause the output-enable is low, clock edges and data-in are ignored, and the transfer continues afterwards at the same bit.
- R6: Read array takes a 16-bit address after the command and then returns array bytes for as long as select stays low; each fetch is a one-cycle request with its address, the byte is taken one cycle later, and the address rises by one per byte, wrapping from FFFF to 0000.
- R7: Write array takes a 16-bit address and then gives one page-load pulse per complete data byte with that byte and its address; only the low 6 address bits advance, wrapping inside the 64-byte page.
- R8: A write is committed only when select rises after at least one complete data byte and on a byte boundary: write array gives a commit pulse, write status gives a status-write pulse carrying the first data byte.
- R9: If select rises in a write array command on anything other than a byte boundary after at least one complete byte, an abort pulse is given instead of a commit.
- R10: While the busy input is high at the end of the command byte, every command except read status is ignored as in R3.
- R11: Read status sends the status input byte, taken again at the start of each byte, repeatedly while select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock, at most a quarter of clk |
| spi_si | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Select, active low |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output-enable for spi_so |
| wr_busy | input | 1 | Internal write cycle in progress |
| status_in | input | 8 | Status byte to send on read status |
| latch_set | output | 1 | Pulse: set write latch |
| latch_clr | output | 1 | Pulse: clear write latch |
| status_wr | output | 1 | Pulse: commit status write |
| status_wr_data | output | 8 | Byte for status write |
| rd_req | output | 1 | Pulse: fetch array byte |
| rd_addr | output | 16 | Fetch address |
| rd_data | input | 8 | Fetched byte, valid the cycle after rd_req |
| page_ld | output | 1 | Pulse: load one page byte |
| page_addr | output | 16 | Address of loaded byte |
| page_data | output | 8 | Loaded byte |
| wr_commit | output | 1 | Pulse: start array write cycle |
| wr_abort | output | 1 | Pulse: discard loaded page |

## Verification
The hardest case to reach is a pause in the middle of a read byte. The pause has to begin and end with the serial clock low, while stray clock pulses and data-in changes arrive during it. The data-out bit in flight must then come back unchanged. The bench reaches it by splitting a read transfer at a chosen bit, dropping the pause line, toggling the clock twice with random data-in and releasing it. It then checks that the output-enable was low inside the pause and that every returned byte still matches the array model. Select rising part-way through a byte is forced the same way, by adding a few spare bits after whole bytes.

// File: rtl/spimf_pkg.sv
package spimf_pkg;
    typedef enum logic [2:0] {
        CMD_BAD, CMD_LSET, CMD_LCLR, CMD_RSTAT, CMD_WSTAT, CMD_RARR, CMD_WARR
    } cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADDR, PH_RDOUT, PH_WRDATA, PH_STWR, PH_IGNORE
    } phase_e;
endpackage

// File: rtl/spimf_sync.sv
module spimf_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/spimf_opdec.sv
module spimf_opdec
    import spimf_pkg::*;
(
    input  logic [7:0] op,
    output cmd_e       cmd
);
    always_comb begin
        cmd = CMD_BAD;
        if (op[7:4] == 4'b0000) begin
            unique case (op[2:0])
                3'b110:  cmd = CMD_LSET;
                3'b100:  cmd = CMD_LCLR;
                3'b101:  cmd = CMD_RSTAT;
                3'b001:  cmd = CMD_WSTAT;
                3'b011:  cmd = CMD_RARR;
                3'b010:  cmd = CMD_WARR;
                default: cmd = CMD_BAD;
            endcase
        end
    end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spimf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    input  logic              spi_cs_n,
    input  logic              spi_hold_n,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              wr_busy,
    input  logic [7:0]        status_in,
    output logic              latch_set,
    output logic              latch_clr,
    output logic              status_wr,
    output logic [7:0]        status_wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              page_ld,
    output logic [ADDR_W-1:0] page_addr,
    output logic [7:0]        page_data,
    output logic              wr_commit,
    output logic              wr_abort
);
    localparam int CNT_W = $clog2(ADDR_W > 8 ? ADDR_W : 8);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        phase_e              phase;
        cmd_e                cmd;
        logic [CNT_W-1:0]    cnt;
        logic [7:0]          sh;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          obuf;
        logic                drive;
        logic                load_pend;
        logic                paused;
        logic                sck_prev;
        logic                cs_prev;
        logic                got;
        logic [7:0]          st_data;
        logic                lset;
        logic                lclr;
        logic                stwr;
        logic                rreq;
        logic                pld;
        logic                commit;
        logic                abort;
        logic [ADDR_W-1:0]   pg_addr;
        logic [7:0]          pg_data;
        logic                so_en;
    } state_t;

    state_t q, n;

    // synchronised inputs: {hold, cs, si, sck}
    logic [3:0] pins_s;
    logic       sck_s, si_s, cs_s, hold_s;

    spimf_sync #(.W(4), .RST_VAL(4'b1100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_hold_n, spi_cs_n, spi_si, spi_sck}),
        .q     (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign si_s   = pins_s[1];
    assign cs_s   = pins_s[2];
    assign hold_s = pins_s[3];

    logic [7:0] in_byte;
    cmd_e       dec_cmd;

    assign in_byte = {q.sh[6:0], si_s};

    spimf_opdec i_dec (
        .op  (in_byte),
        .cmd (dec_cmd)
    );

    logic rise, fall;
    assign rise = sck_s & ~q.sck_prev & ~q.paused;
    assign fall = ~sck_s & q.sck_prev & ~q.paused;

    always_comb begin
        n          = q;
        n.lset     = 1'b0;
        n.lclr     = 1'b0;
        n.stwr     = 1'b0;
        n.rreq     = 1'b0;
        n.pld      = 1'b0;
        n.commit   = 1'b0;
        n.abort    = 1'b0;
        n.sck_prev = sck_s;
        n.cs_prev  = cs_s;

        if (cs_s) begin
            // select released: settle pending writes, then go quiet
            if (!q.cs_prev) begin
                if (q.phase == PH_WRDATA) begin
                    if (q.got && q.cnt == '0) n.commit = 1'b1;
                    else                      n.abort  = 1'b1;
                end else if (q.phase == PH_STWR) begin
                    if (q.got && q.cnt == '0) n.stwr = 1'b1;
                end
            end
            n.phase     = PH_IDLE;
            n.drive     = 1'b0;
            n.load_pend = 1'b0;
            n.paused    = 1'b0;
        end else if (q.cs_prev) begin
            // select just fell: new frame
            n.phase     = PH_OPC;
            n.cnt       = '0;
            n.got       = 1'b0;
            n.drive     = 1'b0;
            n.load_pend = 1'b0;
            n.paused    = 1'b0;
        end else begin
            if (q.paused) n.paused = ~(hold_s & ~sck_s);
            else          n.paused = ~hold_s & ~sck_s;

            if (rise) begin
                unique case (q.phase)
                    PH_OPC: begin
                        n.sh  = in_byte;
                        n.cnt = q.cnt + CNT_ONE;
                        if (q.cnt == BYTE_END) begin
                            n.cnt = '0;
                            n.cmd = dec_cmd;
                            if (wr_busy && dec_cmd != CMD_RSTAT) begin
                                n.phase = PH_IGNORE;
                            end else begin
                                unique case (dec_cmd)
                                    CMD_LSET:  begin n.lset = 1'b1; n.phase = PH_IGNORE; end
                                    CMD_LCLR:  begin n.lclr = 1'b1; n.phase = PH_IGNORE; end
                                    CMD_RSTAT: begin n.phase = PH_RDOUT; n.load_pend = 1'b1; end
                                    CMD_WSTAT: n.phase = PH_STWR;
                                    CMD_RARR:  n.phase = PH_ADDR;
                                    CMD_WARR:  n.phase = PH_ADDR;
                                    default:   n.phase = PH_IGNORE;
                                endcase
                            end
                        end
                    end
                    PH_ADDR: begin
                        n.addr = {q.addr[ADDR_W-2:0], si_s};
                        n.cnt  = q.cnt + CNT_ONE;
                        if (q.cnt == ADDR_END) begin
                            n.cnt = '0;
                            if (q.cmd == CMD_RARR) begin
                                n.phase     = PH_RDOUT;
                                n.rreq      = 1'b1;
                                n.load_pend = 1'b1;
                            end else begin
                                n.phase = PH_WRDATA;
                            end
                        end
                    end
                    PH_RDOUT: begin
                        n.cnt = q.cnt + CNT_ONE;
                        if (q.cnt == BYTE_END) begin
                            n.cnt       = '0;
                            n.load_pend = 1'b1;
                            if (q.cmd == CMD_RARR) n.rreq = 1'b1;
                        end
                    end
                    PH_WRDATA: begin
                        n.sh  = in_byte;
                        n.cnt = q.cnt + CNT_ONE;
                        if (q.cnt == BYTE_END) begin
                            n.cnt     = '0;
                            n.pld     = 1'b1;
                            n.pg_data = in_byte;
                            n.pg_addr = q.addr;
                            n.addr[PAGE_W-1:0] = q.addr[PAGE_W-1:0] + PAGE_W'(1);
                            n.got     = 1'b1;
                        end
                    end
                    PH_STWR: begin
                        n.sh  = in_byte;
                        n.cnt = q.cnt + CNT_ONE;
                        if (q.cnt == BYTE_END) begin
                            n.cnt = '0;
                            if (!q.got) begin
                                n.st_data = in_byte;
                                n.got     = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end else if (fall && q.phase == PH_RDOUT) begin
                if (q.load_pend) begin
                    n.obuf      = (q.cmd == CMD_RARR) ? rd_data : status_in;
                    n.drive     = 1'b1;
                    n.load_pend = 1'b0;
                    if (q.cmd == CMD_RARR) n.addr = q.addr + ADDR_W'(1);
                end else if (q.drive) begin
                    n.obuf = {q.obuf[6:0], 1'b0};
                end
            end
        end

        n.so_en = n.drive & ~n.paused;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.cs_prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    // signals exposed for the bound checker
    logic pause_q;
    assign pause_q = q.paused;

    assign spi_so         = q.obuf[7];
    assign spi_so_oe      = q.so_en;
    assign latch_set      = q.lset;
    assign latch_clr      = q.lclr;
    assign status_wr      = q.stwr;
    assign status_wr_data = q.st_data;
    assign rd_req         = q.rreq;
    assign rd_addr        = q.addr;
    assign page_ld        = q.pld;
    assign page_addr      = q.pg_addr;
    assign page_data      = q.pg_data;
    assign wr_commit      = q.commit;
    assign wr_abort       = q.abort;
endmodule

// File: rtl/spimf_chk.sv
module spimf_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic pause_q,
    input logic wr_busy,
    input logic spi_so_oe,
    input logic latch_set,
    input logic latch_clr,
    input logic status_wr,
    input logic rd_req,
    input logic wr_commit,
    input logic wr_abort
);
    // R4
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_so_oe);

    // R5
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_q |-> !spi_so_oe);

    // R9
    commit_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_commit && wr_abort));

    // R8
    commit_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit || status_wr) |-> $past(cs_s));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({latch_set, latch_clr, status_wr, wr_commit, wr_abort}));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_set || latch_clr) |-> !$past(wr_busy));

    // R6
    fetch_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !$past(cs_s));
endmodule

bind spi_mem_front spimf_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .pause_q   (pause_q),
    .wr_busy   (wr_busy),
    .spi_so_oe (spi_so_oe),
    .latch_set (latch_set),
    .latch_clr (latch_clr),
    .status_wr (status_wr),
    .rd_req    (rd_req),
    .wr_commit (wr_commit),
    .wr_abort  (wr_abort)
);

// File: tb/test_spi_mem_front.sv
`timescale 1ns/1ps
module test_spi_mem_front;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0, spi_si = 1'b0, spi_cs_n = 1'b1, spi_hold_n = 1'b1;
    logic        spi_so, spi_so_oe;
    logic        wr_busy = 1'b0;
    logic [7:0]  status_in = 8'hA5;
    logic        latch_set, latch_clr, status_wr, rd_req, page_ld, wr_commit, wr_abort;
    logic [7:0]  status_wr_data, page_data;
    logic [7:0]  rd_data = 8'h00;
    logic [15:0] rd_addr, page_addr;

    always #10 clk = ~clk;

    spi_mem_front i_spi_mem_front (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_si(spi_si),
        .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n), .spi_so(spi_so),
        .spi_so_oe(spi_so_oe), .wr_busy(wr_busy), .status_in(status_in),
        .latch_set(latch_set), .latch_clr(latch_clr), .status_wr(status_wr),
        .status_wr_data(status_wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .page_ld(page_ld), .page_addr(page_addr),
        .page_data(page_data), .wr_commit(wr_commit), .wr_abort(wr_abort)
    );

    int checks = 0, failures = 0;
    int n_set = 0, n_clr = 0, n_stwr = 0, n_req = 0, n_pl = 0, n_com = 0, n_abt = 0;
    logic [7:0]  last_st = 8'h00;
    logic [15:0] pl_addr [0:31];
    logic [7:0]  pl_data [0:31];
    logic [7:0]  txb [0:15];
    logic [7:0]  rxb [0:15];
    logic        any_oe, hold_oe, resume_oe;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] page_step(input logic [15:0] a, input int i);
        logic [5:0] lo;
        lo = a[5:0] + 6'(i);
        return {a[15:6], lo};
    endfunction

    // array model and parallel-side monitor
    always @(posedge clk) begin
        if (rd_req) begin rd_data <= mem_f(rd_addr); n_req <= n_req + 1; end
        if (latch_set) n_set <= n_set + 1;
        if (latch_clr) n_clr <= n_clr + 1;
        if (status_wr) begin n_stwr <= n_stwr + 1; last_st <= status_wr_data; end
        if (page_ld) begin
            pl_addr[n_pl % 32] <= page_addr;
            pl_data[n_pl % 32] <= page_data;
            n_pl <= n_pl + 1;
        end
        if (wr_commit) n_com <= n_com + 1;
        if (wr_abort)  n_abt <= n_abt + 1;
    end

    task automatic wclk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input int nbytes, input bit m3, input int hold_at, input int extra);
        int total;
        any_oe = 0; hold_oe = 0; resume_oe = 1;
        for (int i = 0; i < 16; i++) rxb[i] = 8'h00;
        spi_sck = m3;
        wclk(HALF);
        spi_cs_n = 1'b0;
        wclk(HALF);
        total = nbytes * 8 + extra;
        for (int b = 0; b < total; b++) begin
            spi_sck = 1'b0;
            if (b == hold_at) begin
                wclk(HALF);
                spi_hold_n = 1'b0;
                wclk(6);
                if (spi_so_oe) hold_oe = 1;
                for (int t = 0; t < 2; t++) begin
                    spi_si = 1'($urandom);
                    spi_sck = 1'b1; wclk(HALF);
                    if (spi_so_oe) hold_oe = 1;
                    spi_sck = 1'b0; wclk(HALF);
                end
                spi_hold_n = 1'b1;
            end
            spi_si = txb[b / 8][7 - (b % 8)];
            wclk(HALF);
            if (b == hold_at) resume_oe = spi_so_oe;
            if (spi_so_oe) any_oe = 1;
            rxb[b / 8][7 - (b % 8)] = spi_so_oe ? spi_so : 1'b0;
            spi_sck = 1'b1;
            wclk(HALF);
        end
        if (!m3) begin spi_sck = 1'b0; wclk(HALF); end
        spi_cs_n = 1'b1;
        wclk(2 * HALF + 4);
    endtask

    task automatic do_read(input logic [15:0] a, input int nb, input bit m3,
                           input int hold_at, input string req);
        txb[0] = 8'h03; txb[1] = a[15:8]; txb[2] = a[7:0];
        xfer(3 + nb, m3, hold_at, 0);
        for (int i = 0; i < nb; i++)
            chk(rxb[3 + i] == mem_f(a + 16'(i)), req, "read byte",
                int'(rxb[3 + i]), int'(mem_f(a + 16'(i))));
    endtask

    initial begin
        int s0, s1, s2, s3;
        logic [15:0] a;
        void'($urandom(32'h5EED_0042));
        wclk(5);
        rst_n = 1'b1;
        wclk(4);
        chk(spi_so_oe == 1'b0, "R4", "reset oe", int'(spi_so_oe), 0);
        chk(n_set == 0 && n_com == 0, "R4", "reset pulses", n_set + n_com, 0);

        // R2 set and clear latch, bit 3 ignored
        s0 = n_set; s1 = n_clr;
        txb[0] = 8'h06; xfer(1, 0, -1, 0);
        chk(n_set == s0 + 1, "R2", "set latch", n_set - s0, 1);
        txb[0] = 8'h0E; xfer(1, 1, -1, 0);
        chk(n_set == s0 + 2, "R2", "set latch bit3", n_set - s0, 2);
        txb[0] = 8'h04; xfer(1, 0, -1, 0);
        chk(n_clr == s1 + 1, "R2", "clear latch", n_clr - s1, 1);

        // R4 clocks with select high do nothing
        s0 = n_set;
        for (int b = 0; b < 8; b++) begin
            spi_si = 8'h06 >> (7 - b);
            spi_sck = 1'b1; wclk(HALF);
            chk(spi_so_oe == 1'b0, "R4", "oe while deselected", int'(spi_so_oe), 0);
            spi_sck = 1'b0; wclk(HALF);
        end
        wclk(8);
        chk(n_set == s0, "R4", "no pulse while deselected", n_set - s0, 0);

        // R11 status read, both modes
        status_in = 8'hA5;
        txb[0] = 8'h05; xfer(3, 1, -1, 0);
        chk(rxb[1] == 8'hA5 && rxb[2] == 8'hA5, "R11", "status mode3",
            int'({rxb[1], rxb[2]}), 16'hA5A5);
        status_in = 8'h3C;
        txb[0] = 8'h0D; xfer(2, 0, -1, 0);
        chk(rxb[1] == 8'h3C, "R11", "status mode0", int'(rxb[1]), 8'h3C);

        // R1 R6 random reads
        for (int k = 0; k < 10; k++) begin
            a = 16'($urandom);
            do_read(a, 2 + int'($urandom % 3), 1'($urandom), -1, "R1");
        end
        // R6 wrap at top address
        do_read(16'hFFFE, 4, 0, -1, "R6");
        s0 = n_req;
        do_read(16'h0100, 3, 1, -1, "R6");
        chk(n_req - s0 >= 3, "R6", "fetch requests", n_req - s0, 3);

        // R5 pause in middle of a data byte
        do_read(16'h4A17, 3, 0, 3 * 8 + 11, "R5");
        chk(hold_oe == 1'b0, "R5", "oe during pause", int'(hold_oe), 0);
        chk(resume_oe == 1'b1, "R5", "oe after pause", int'(resume_oe), 1);
        do_read(16'h0033, 2, 1, 3 * 8 + 2, "R5");
        chk(hold_oe == 1'b0, "R5", "oe during pause m3", int'(hold_oe), 0);

        // R7 R8 page write with wrap inside page
        s0 = n_pl; s1 = n_com; s2 = n_abt;
        txb[0] = 8'h02; txb[1] = 8'h12; txb[2] = 8'h3E;
        for (int i = 0; i < 3; i++) txb[3 + i] = 8'($urandom);
        xfer(6, 0, -1, 0);
        chk(n_pl == s0 + 3, "R7", "page loads", n_pl - s0, 3);
        for (int i = 0; i < 3; i++) begin
            chk(pl_addr[(s0 + i) % 32] == page_step(16'h123E, i), "R7", "page addr",
                int'(pl_addr[(s0 + i) % 32]), int'(page_step(16'h123E, i)));
            chk(pl_data[(s0 + i) % 32] == txb[3 + i], "R7", "page data",
                int'(pl_data[(s0 + i) % 32]), int'(txb[3 + i]));
        end
        chk(n_com == s1 + 1 && n_abt == s2, "R8", "commit", n_com - s1, 1);

        // R9 select rises mid-byte
        s0 = n_pl; s1 = n_com; s2 = n_abt;
        txb[0] = 8'h02; txb[1] = 8'h00; txb[2] = 8'h10; txb[3] = 8'h11; txb[4] = 8'h22;
        txb[5] = 8'hFF;
        xfer(5, 1, -1, 3);
        chk(n_pl == s0 + 2, "R9", "loads before cut", n_pl - s0, 2);
        chk(n_com == s1, "R9", "no commit", n_com - s1, 0);
        chk(n_abt == s2 + 1, "R9", "abort", n_abt - s2, 1);

        // R8 status write, complete and cut
        s0 = n_stwr;
        txb[0] = 8'h01; txb[1] = 8'h8C; xfer(2, 0, -1, 0);
        chk(n_stwr == s0 + 1 && last_st == 8'h8C, "R8", "status write",
            int'(last_st), 8'h8C);
        s0 = n_stwr;
        txb[0] = 8'h01; txb[1] = 8'h44; xfer(1, 0, -1, 5);
        chk(n_stwr == s0, "R8", "cut status write", n_stwr - s0, 0);

        // R3 invalid opcodes lock out the frame
        s0 = n_set; s1 = n_req;
        txb[0] = 8'h07; txb[1] = 8'h06; xfer(2, 0, -1, 0);
        chk(n_set == s0 && any_oe == 0, "R3", "lockout 07", n_set - s0, 0);
        txb[0] = 8'h43; txb[1] = 8'h00; txb[2] = 8'h00; xfer(4, 1, -1, 0);
        chk(n_req == s1 && any_oe == 0, "R3", "lockout 43", n_req - s1, 0);
        do_read(16'h2222, 1, 0, -1, "R3");

        // R10 busy blocks all but status read
        wr_busy = 1'b1;
        s0 = n_set; s1 = n_req; s3 = n_pl;
        txb[0] = 8'h06; xfer(1, 0, -1, 0);
        chk(n_set == s0, "R10", "busy set ignored", n_set - s0, 0);
        txb[0] = 8'h03; txb[1] = 8'h10; txb[2] = 8'h00; xfer(4, 0, -1, 0);
        chk(n_req == s1 && any_oe == 0, "R10", "busy read ignored", n_req - s1, 0);
        txb[0] = 8'h02; txb[3] = 8'h5A; xfer(4, 1, -1, 0);
        chk(n_pl == s3, "R10", "busy write ignored", n_pl - s3, 0);
        status_in = 8'h81;
        txb[0] = 8'h05; xfer(2, 0, -1, 0);
        chk(rxb[1] == 8'h81, "R10", "busy status read", int'(rxb[1]), 8'h81);
        wr_busy = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule